// File: doc/BRIEF.md
# Stepped Timebase Counter with Snapshot Read

This block keeps a 64-bit system time count. Each cycle where the clock-enable pulse is high and counting is allowed, the count grows by a programmable step. Two step registers exist, one for the fast time source and one for the slow one. The source-select input picks which step is active, so the count keeps the same rate in time units after a source change. The defaults are 1 for the fast source (80 ticks per microsecond) and 2 for the slow source (40 ticks per microsecond). A slow source divided down to 10 MHz would need a step of 8.

Software never reads the running count directly. It raises a snapshot request, waits for the valid flag, then reads the frozen value as a low and a high 32-bit word. To set a new time, software writes the two load words and then pulses an apply strobe. Any CPU can freeze the count while it is halted, but only if its stall permission bit is set.

Top module: `tbc_timebase`

## Requirements
- R1: After reset the count is 0, the snapshot flag is low, both snapshot words are 0, the fast step is 1 and the slow step is 2.
- R2: With `src_slow`=0, `cnt_enable`=1, `tick_en`=1 and no active stall, the count grows by the fast step at each clock edge.
- R3: With `src_slow`=1 under the same conditions, the count grows by the slow step instead.
- R4: A write strobe on `step_fast_wr` or `step_slow_wr` stores `step_wdata` into that step register only. The new value is used from the following cycle on.
- R5: When `cnt_enable`=0 or `tick_en`=0, the count does not change.
- R6: When for some CPU i both `stall_perm[i]` and `cpu_stall[i]` are 1, the count holds. A stall on a CPU whose permission bit is 0 has no effect.
- R7: `load_lo_wr` and `load_hi_wr` store `load_wdata` into the low and high load words. `apply_stb` puts {high,low} into the count at the next edge. In that cycle the apply wins over any increment.
- R8: A `snap_req` seen at an edge drives `snap_valid` low at that edge. At the following edge, `snap_valid` goes high and `snap_lo`/`snap_hi` take the count held between those two edges.
- R9: `snap_lo` and `snap_hi` keep their value until a later request is captured.
- R10: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable pulse |
| src_slow | input | 1 | 1 selects the slow source step |
| cnt_enable | input | 1 | Master count enable |
| step_fast_wr | input | 1 | Write strobe for the fast step |
| step_slow_wr | input | 1 | Write strobe for the slow step |
| step_wdata | input | 8 | Step write data |
| load_lo_wr | input | 1 | Write strobe for the low load word |
| load_hi_wr | input | 1 | Write strobe for the high load word |
| load_wdata | input | 32 | Load word write data |
| apply_stb | input | 1 | Copy the load words into the count |
| stall_perm | input | 2 | Per-CPU stall permission |
| cpu_stall | input | 2 | Per-CPU stall request |
| snap_req | input | 1 | Snapshot request |
| snap_valid | output | 1 | Snapshot words are ready |
| snap_lo | output | 32 | Snapshot low word |
| snap_hi | output | 32 | Snapshot high word |

## Verification
The assertions check these rules on every cycle: the count holds when it is idle or stalled, it grows by exactly the active step, an apply loads the count, step writes are stored, the valid flag falls and then rises, and the snapshot words stay stable. The bench scenarios show what only the ports can reveal. They sweep step pairs on both sources, check that a stall without permission is ignored, and check that apply wins over an increment. They also run the wrap past 2^64 and confirm that the words stay frozen while counting goes on.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] ld_lo;
        logic [WORD_W-1:0] ld_hi;
    } core_st_t;

    typedef struct packed {
        logic              valid;
        logic              pend;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } snap_st_t;
endpackage

// File: rtl/tbc_step_sel.sv
module tbc_step_sel #(
    parameter int STEP_W   = 8,
    parameter int FAST_DEF = 1,
    parameter int SLOW_DEF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_slow,
    input  logic              fast_wr,
    input  logic              slow_wr,
    input  logic [STEP_W-1:0] wdata,
    output logic [STEP_W-1:0] step_active
);
    typedef struct packed {
        logic [STEP_W-1:0] fast;
        logic [STEP_W-1:0] slow;
    } step_st_t;

    step_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fast_wr) st_d.fast = wdata;
        if (slow_wr) st_d.slow = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fast <= STEP_W'(FAST_DEF);
            st_q.slow <= STEP_W'(SLOW_DEF);
        end else begin
            st_q <= st_d;
        end
    end

    assign step_active = src_slow ? st_q.slow : st_q.fast;

    // R4: a write lands in the addressed register; the other one keeps its value
    a_r4_fast_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_wr && !slow_wr) |=> (st_q.fast == $past(wdata)) && $stable(st_q.slow));
    a_r4_slow_write: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_wr && !fast_wr) |=> (st_q.slow == $past(wdata)) && $stable(st_q.fast));
endmodule

// File: rtl/tbc_stall_gate.sv
module tbc_stall_gate #(
    parameter int NCPU = 2
) (
    input  logic [NCPU-1:0] perm,
    input  logic [NCPU-1:0] stall,
    output logic            stall_hit
);
    logic [NCPU-1:0] hit;

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        assign hit[i] = perm[i] & stall[i];
    end

    assign stall_hit = |hit;
endmodule

// File: rtl/tbc_count_core.sv
module tbc_count_core
    import tbc_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_ok,
    input  logic [STEP_W-1:0] step,
    input  logic              ld_lo_wr,
    input  logic              ld_hi_wr,
    input  logic [WORD_W-1:0] ld_wdata,
    input  logic              apply,
    output logic [CNT_W-1:0]  count
);
    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo_wr) st_d.ld_lo = ld_wdata;
        if (ld_hi_wr) st_d.ld_hi = ld_wdata;
        if (apply)
            st_d.count = {st_q.ld_hi, st_q.ld_lo};
        else if (inc_ok)
            st_d.count = st_q.count + CNT_W'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    // R7: apply copies the load words and wins over an increment
    a_r7_apply_loads: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> count == {$past(st_q.ld_hi), $past(st_q.ld_lo)});
    // R2/R3/R10: an increment adds exactly the step, modulo 2^64
    a_r2_step_add: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ok && !apply) |=> count == $past(count) + CNT_W'($past(step)));
    // R5/R6: without an increment or an apply the count holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_ok && !apply) |=> $stable(count));
endmodule

// File: rtl/tbc_snap.sv
module tbc_snap
    import tbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CNT_W-1:0]  count,
    output logic              valid,
    output logic [WORD_W-1:0] lo,
    output logic [WORD_W-1:0] hi
);
    snap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req) begin
            st_d.valid = 1'b0;
            st_d.pend  = 1'b1;
        end else if (st_q.pend) begin
            st_d.lo    = count[WORD_W-1:0];
            st_d.hi    = count[CNT_W-1:WORD_W];
            st_d.valid = 1'b1;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign lo    = st_q.lo;
    assign hi    = st_q.hi;

    // R8: a request drops the flag
    a_r8_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !valid);
    // R8: a pending capture raises the flag with the current count
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !req) |=> valid && ({hi, lo} == $past(count)));
    // R9: without a pending capture the words do not move
    a_r9_words_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> $stable(lo) && $stable(hi));
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase
    import tbc_pkg::*;
#(
    parameter int STEP_W   = 8,
    parameter int NCPU     = 2,
    parameter int FAST_DEF = 1,
    parameter int SLOW_DEF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              src_slow,
    input  logic              cnt_enable,
    input  logic              step_fast_wr,
    input  logic              step_slow_wr,
    input  logic [STEP_W-1:0] step_wdata,
    input  logic              load_lo_wr,
    input  logic              load_hi_wr,
    input  logic [WORD_W-1:0] load_wdata,
    input  logic              apply_stb,
    input  logic [NCPU-1:0]   stall_perm,
    input  logic [NCPU-1:0]   cpu_stall,
    input  logic              snap_req,
    output logic              snap_valid,
    output logic [WORD_W-1:0] snap_lo,
    output logic [WORD_W-1:0] snap_hi
);
    logic [STEP_W-1:0] step_active;
    logic              stall_hit;
    logic              inc_ok;
    logic [CNT_W-1:0]  count;

    tbc_step_sel #(
        .STEP_W(STEP_W), .FAST_DEF(FAST_DEF), .SLOW_DEF(SLOW_DEF)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .src_slow(src_slow),
        .fast_wr(step_fast_wr), .slow_wr(step_slow_wr),
        .wdata(step_wdata), .step_active(step_active)
    );

    tbc_stall_gate #(.NCPU(NCPU)) u_stall (
        .perm(stall_perm), .stall(cpu_stall), .stall_hit(stall_hit)
    );

    assign inc_ok = tick_en & cnt_enable & ~stall_hit;

    tbc_count_core #(.STEP_W(STEP_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc_ok(inc_ok), .step(step_active),
        .ld_lo_wr(load_lo_wr), .ld_hi_wr(load_hi_wr), .ld_wdata(load_wdata),
        .apply(apply_stb), .count(count)
    );

    tbc_snap u_snap (
        .clk(clk), .rst_n(rst_n), .req(snap_req), .count(count),
        .valid(snap_valid), .lo(snap_lo), .hi(snap_hi)
    );

    // R6: a permitted stall freezes the count unless an apply happens
    a_r6_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stall_perm & cpu_stall) && !apply_stb) |=> $stable(count));
endmodule

// File: tb/tb_tbc_timebase.sv
`timescale 1ns/1ps
module tb_tbc_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, src_slow = 1'b0, cnt_enable = 1'b0;
    logic        step_fast_wr = 1'b0, step_slow_wr = 1'b0;
    logic [7:0]  step_wdata = '0;
    logic        load_lo_wr = 1'b0, load_hi_wr = 1'b0;
    logic [31:0] load_wdata = '0;
    logic        apply_stb = 1'b0;
    logic [1:0]  stall_perm = '0, cpu_stall = '0;
    logic        snap_req = 1'b0;
    logic        snap_valid;
    logic [31:0] snap_lo, snap_hi;

    int total = 0, bad = 0;
    logic [63:0] m_cnt = '0;
    logic [7:0]  m_fast = 8'd1, m_slow = 8'd2;
    logic [31:0] m_lo = '0, m_hi = '0;

    always #4 clk = ~clk;

    tbc_timebase dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_slow(src_slow),
        .cnt_enable(cnt_enable), .step_fast_wr(step_fast_wr),
        .step_slow_wr(step_slow_wr), .step_wdata(step_wdata),
        .load_lo_wr(load_lo_wr), .load_hi_wr(load_hi_wr), .load_wdata(load_wdata),
        .apply_stb(apply_stb), .stall_perm(stall_perm), .cpu_stall(cpu_stall),
        .snap_req(snap_req), .snap_valid(snap_valid),
        .snap_lo(snap_lo), .snap_hi(snap_hi)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock edge; the model follows the requirements using the inputs seen there
    task automatic cyc();
        logic stalled;
        @(posedge clk);
        stalled = |(stall_perm & cpu_stall);
        if (apply_stb) m_cnt = {m_hi, m_lo};
        else if (tick_en && cnt_enable && !stalled)
            m_cnt = m_cnt + 64'(src_slow ? m_slow : m_fast);
        if (step_fast_wr) m_fast = step_wdata;
        if (step_slow_wr) m_slow = step_wdata;
        if (load_lo_wr) m_lo = load_wdata;
        if (load_hi_wr) m_hi = load_wdata;
        @(negedge clk);
    endtask

    task automatic snap_check(input string tag);
        logic [63:0] exp;
        snap_req = 1'b1;
        cyc();
        snap_req = 1'b0;
        chk({tag, " R8 valid low"}, 64'(snap_valid), 64'd0);
        exp = m_cnt;
        cyc();
        chk({tag, " R8 valid high"}, 64'(snap_valid), 64'd1);
        chk(tag, {snap_hi, snap_lo}, exp);
    endtask

    task automatic load(input logic [63:0] v);
        load_lo_wr = 1'b1; load_wdata = v[31:0]; cyc(); load_lo_wr = 1'b0;
        load_hi_wr = 1'b1; load_wdata = v[63:32]; cyc(); load_hi_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 64'(snap_valid), 64'd0);
        chk("R1 words", {snap_hi, snap_lo}, 64'd0);
        snap_check("R1 count zero");

        // R1 default steps, R2 and R3 with default values
        cnt_enable = 1'b1; tick_en = 1'b1;
        src_slow = 1'b0; repeat (5) cyc(); snap_check("R2 default fast step");
        src_slow = 1'b1; repeat (5) cyc(); snap_check("R3 default slow step");

        // R4 sweep over step pairs, with both sources and a gapped tick pattern
        for (int sf = 1; sf <= 4; sf++) begin
            for (int ss = 5; ss <= 8; ss++) begin
                step_wdata = 8'(sf); step_fast_wr = 1'b1; cyc(); step_fast_wr = 1'b0;
                step_wdata = 8'(ss); step_slow_wr = 1'b1; cyc(); step_slow_wr = 1'b0;
                for (int s = 0; s < 2; s++) begin
                    src_slow = s[0];
                    for (int k = 0; k < 6; k++) begin
                        tick_en = (k % 3) != 1;
                        cyc();
                    end
                    tick_en = 1'b1;
                    snap_check(s == 0 ? "R4 R2 fast sweep" : "R4 R3 slow sweep");
                end
            end
        end

        // R5 enable off, and tick off
        cnt_enable = 1'b0; repeat (4) cyc();
        snap_check("R5 enable off holds");
        cnt_enable = 1'b1; tick_en = 1'b0; repeat (4) cyc(); tick_en = 1'b1;
        snap_check("R5 tick off holds");

        // R6 stall with and without permission
        stall_perm = 2'b01; cpu_stall = 2'b10; repeat (4) cyc();
        snap_check("R6 stall without permission ignored");
        cpu_stall = 2'b01; held = m_cnt; repeat (4) cyc();
        chk("R6 model hold", m_cnt, held);
        snap_req = 1'b1; cyc(); snap_req = 1'b0; cyc();
        chk("R6 permitted stall holds", {snap_hi, snap_lo}, held);
        stall_perm = 2'b11; cpu_stall = 2'b10; repeat (3) cyc();
        snap_check("R6 second cpu stall");
        cpu_stall = 2'b00;

        // R7 apply with a concurrent tick, R10 wrap
        src_slow = 1'b1; step_wdata = 8'd3; step_slow_wr = 1'b1; cyc(); step_slow_wr = 1'b0;
        load(64'hFFFF_FFFF_FFFF_FFF0);
        tick_en = 1'b1; apply_stb = 1'b1; cyc(); apply_stb = 1'b0;
        chk("R7 model load", m_cnt, 64'hFFFF_FFFF_FFFF_FFF0);
        tick_en = 1'b0;
        snap_check("R7 apply beats tick");
        tick_en = 1'b1; repeat (6) cyc();
        snap_check("R10 wrap past 2^64");
        chk("R10 wrapped low", m_cnt < 64'h100 ? 64'd1 : 64'd0, 64'd1);

        // R9 words frozen while counting continues
        held = {snap_hi, snap_lo};
        repeat (10) cyc();
        chk("R9 words stable", {snap_hi, snap_lo}, held);
        chk("R9 valid stays", 64'(snap_valid), 64'd1);
        snap_check("R9 next request refreshes");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule